// File: doc/BRIEF.md
# Floating-Point Exception Priority Arbiter

This block sits after a single-precision add, subtract, multiply or divide datapath and turns that unit's raw exception indications into a single verdict. It takes the two source operands, six raw indications, result-class hints (tiny, huge, result is NaN), a six-bit mask word and the flush-to-zero and denormals-are-zero controls. From these it decides whether a trap must be raised, which cause to report and which status flags to set. It also produces a select code that tells the result mux what to deliver.

Decisions follow a fixed order. Faults are resolved first: invalid, then NaN operand handling, then denormal operand, then divide-by-zero. A NaN result is handled next. The result-dependent traps come last: underflow, then overflow, then inexact. When nothing traps, every raw indication is copied into its flag. The arithmetic and rounding are outside this block.

Top module: `fpx_trap_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all outputs are zero.
- R2: A verdict appears one clock after `in_valid` with `out_valid` high for that one cycle. Without `in_valid` the outputs hold and `out_valid` is low.
- R3: Masks and flags use bit 0 invalid, bit 1 denormal, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow, bit 5 precision. A clear mask bit enables that trap. `cause` is 0 none, 1 invalid, 2 denormal, 3 divide-by-zero, 4 overflow, 5 underflow, 6 inexact. It is nonzero exactly when `raise_trap` is high.
- R4: An enabled invalid with the raw invalid indication set wins over everything else. It gives trap, cause 1 and flags 0x01.
- R5: If either operand is a NaN and R4 did not fire, no trap is raised. Flags are 0x01 if raw invalid is set, else 0. `res_sel` is 1 (quieted first operand) when both operands are NaN and 0 (computed result) otherwise.
- R6: Raw denormal is dropped whenever raw divide-by-zero is set. Otherwise an enabled denormal traps (cause 2, flag 0x02) before an enabled divide-by-zero (cause 3, flag 0x04).
- R7: With `daz` high the raw denormal indication is ignored entirely.
- R8: If no earlier rule fired and `res_nan` is high, the result is delivered with flags 0x01 and no trap.
- R9: An enabled underflow with a tiny result traps with cause 5 before an enabled overflow with a huge result traps with cause 4. The trap sets its own flag, plus precision when the raw precision indication is set.
- R10: An enabled inexact traps (cause 6) on raw precision, or on flush-to-zero with a tiny result. It sets precision, plus underflow if tiny and overflow if huge. `res_sel` is 2 (signed zero) when flush-to-zero and tiny both hold.
- R11: With no trap, every raw indication is copied into its flag. Flush-to-zero with a tiny result also sets underflow and precision and gives `res_sel` 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation status present this cycle |
| opa | input | 32 | First source operand |
| opb | input | 32 | Second source operand |
| raw_flags | input | 6 | Raw exception indications (R3 bit order) |
| res_tiny | input | 1 | Rounded result is below the smallest normal |
| res_huge | input | 1 | Rounded result is above the largest normal |
| res_nan | input | 1 | Computed result is a NaN |
| exc_mask | input | 6 | Trap masks, 1 = masked (R3 bit order) |
| ftz | input | 1 | Flush-to-zero enable |
| daz | input | 1 | Denormals-are-zero enable |
| out_valid | output | 1 | Verdict valid strobe |
| raise_trap | output | 1 | A trap must be taken |
| cause | output | 3 | Encoded trap cause |
| flags | output | 6 | Status flags to set |
| res_sel | output | 2 | Result select: 0 computed, 1 quiet opa, 2 signed zero |

## Verification
On every cycle the assertions check the link between `cause` and `raise_trap`, the one-cycle latency and the hold behaviour. They also check that invalid wins when enabled, that NaN operands never trap outside that case, that denormal is hidden behind divide-by-zero and under `daz`, and that a flush select always carries the underflow and precision flags. The rest depends on chosen stimulus, so only the directed scenarios can show it. That covers the exact flag sets per path, the underflow-over-overflow order, the two-NaN select, the inexact trap triggered by flush-to-zero alone, and the no-trap copy of raw indications.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int FLAG_N = 6;
    localparam int F_INV  = 0;
    localparam int F_DEN  = 1;
    localparam int F_DBZ  = 2;
    localparam int F_OVF  = 3;
    localparam int F_UNF  = 4;
    localparam int F_PRE  = 5;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_INV  = 3'd1,
        CAUSE_DEN  = 3'd2,
        CAUSE_DBZ  = 3'd3,
        CAUSE_OVF  = 3'd4,
        CAUSE_UNF  = 3'd5,
        CAUSE_PRE  = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        SEL_CALC   = 2'd0,
        SEL_QNAN_A = 2'd1,
        SEL_FLUSH  = 2'd2
    } rsel_e;

    typedef struct packed {
        logic              vld;
        logic              trap;
        cause_e            cause;
        logic [FLAG_N-1:0] flags;
        rsel_e             sel;
    } verdict_t;
endpackage

// File: rtl/fpx_nan_detect.sv
module fpx_nan_detect #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] val,
    output logic         is_nan
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    always_comb begin
        expo   = val[W-2 -: EXP_W];
        mant   = val[MAN_W-1:0];
        is_nan = (&expo) && (|mant);
    end
endmodule

// File: rtl/fpx_flag_prep.sv
module fpx_flag_prep
    import fpx_pkg::*;
(
    input  logic [FLAG_N-1:0] raw,
    input  logic [FLAG_N-1:0] mask,
    input  logic              daz,
    output logic [FLAG_N-1:0] clean,
    output logic [FLAG_N-1:0] en
);
    always_comb begin
        clean = raw;
        // a zero divisor hides the denormal indication; DAZ removes it
        if (raw[F_DBZ] || daz) begin
            clean[F_DEN] = 1'b0;
        end
        en = ~mask;
    end
endmodule

// File: rtl/fpx_priority.sv
module fpx_priority
    import fpx_pkg::*;
(
    input  logic [FLAG_N-1:0] clean,
    input  logic [FLAG_N-1:0] en,
    input  logic              nan_a,
    input  logic              nan_b,
    input  logic              tiny,
    input  logic              huge,
    input  logic              res_nan,
    input  logic              ftz,
    output verdict_t          v
);
    logic flush;

    always_comb begin
        flush   = ftz && tiny;
        v       = '0;
        v.vld   = 1'b1;
        v.cause = CAUSE_NONE;
        v.sel   = SEL_CALC;

        if (en[F_INV] && clean[F_INV]) begin
            v.trap         = 1'b1;
            v.cause        = CAUSE_INV;
            v.flags[F_INV] = 1'b1;
        end else if (nan_a || nan_b) begin
            v.flags[F_INV] = clean[F_INV];
            v.sel          = (nan_a && nan_b) ? SEL_QNAN_A : SEL_CALC;
        end else if (en[F_DEN] && clean[F_DEN]) begin
            v.trap         = 1'b1;
            v.cause        = CAUSE_DEN;
            v.flags[F_DEN] = 1'b1;
        end else if (en[F_DBZ] && clean[F_DBZ]) begin
            v.trap         = 1'b1;
            v.cause        = CAUSE_DBZ;
            v.flags[F_DBZ] = 1'b1;
        end else if (res_nan) begin
            v.flags[F_INV] = 1'b1;
        end else begin
            v.flags[F_DEN] = clean[F_DEN];
            if (en[F_UNF] && tiny) begin
                v.trap         = 1'b1;
                v.cause        = CAUSE_UNF;
                v.flags[F_UNF] = 1'b1;
                v.flags[F_PRE] = clean[F_PRE];
            end else if (en[F_OVF] && huge) begin
                v.trap         = 1'b1;
                v.cause        = CAUSE_OVF;
                v.flags[F_OVF] = 1'b1;
                v.flags[F_PRE] = clean[F_PRE];
            end else if (en[F_PRE] && (clean[F_PRE] || flush)) begin
                v.trap         = 1'b1;
                v.cause        = CAUSE_PRE;
                v.flags[F_PRE] = 1'b1;
                v.flags[F_UNF] = tiny;
                v.flags[F_OVF] = huge;
                v.sel          = flush ? SEL_FLUSH : SEL_CALC;
            end else begin
                v.flags = clean;
                if (flush) begin
                    v.flags[F_UNF] = 1'b1;
                    v.flags[F_PRE] = 1'b1;
                    v.sel          = SEL_FLUSH;
                end
            end
        end
    end
endmodule

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter
    import fpx_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [FLAG_N-1:0] raw_flags,
    input  logic              res_tiny,
    input  logic              res_huge,
    input  logic              res_nan,
    input  logic [FLAG_N-1:0] exc_mask,
    input  logic              ftz,
    input  logic              daz,
    output logic              out_valid,
    output logic              raise_trap,
    output logic [2:0]        cause,
    output logic [FLAG_N-1:0] flags,
    output logic [1:0]        res_sel
);
    logic [1:0][W-1:0]  ops;
    logic [1:0]         op_nan;
    logic [FLAG_N-1:0]  clean;
    logic [FLAG_N-1:0]  en;
    verdict_t           verdict;
    verdict_t           state_d;
    verdict_t           state_q;

    assign ops[0] = opa;
    assign ops[1] = opb;

    for (genvar i = 0; i < 2; i++) begin : g_nan
        fpx_nan_detect #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
            .val    (ops[i]),
            .is_nan (op_nan[i])
        );
    end

    fpx_flag_prep u_prep (
        .raw   (raw_flags),
        .mask  (exc_mask),
        .daz   (daz),
        .clean (clean),
        .en    (en)
    );

    fpx_priority u_prio (
        .clean   (clean),
        .en      (en),
        .nan_a   (op_nan[0]),
        .nan_b   (op_nan[1]),
        .tiny    (res_tiny),
        .huge    (res_huge),
        .res_nan (res_nan),
        .ftz     (ftz),
        .v       (verdict)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (in_valid) begin
            state_d = verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.vld;
    assign raise_trap = state_q.trap;
    assign cause      = state_q.cause;
    assign flags      = state_q.flags;
    assign res_sel    = state_q.sel;
endmodule

// File: rtl/fpx_trap_arbiter_chk.sv
module fpx_trap_arbiter_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic [5:0]  raw_flags,
    input logic [5:0]  exc_mask,
    input logic        daz,
    input logic        out_valid,
    input logic        raise_trap,
    input logic [2:0]  cause,
    input logic [5:0]  flags,
    input logic [1:0]  res_sel
);
    logic any_nan;
    assign any_nan = ((&opa[30:23]) && (|opa[22:0])) || ((&opb[30:23]) && (|opb[22:0]));

    assert_trap_has_cause_R3: assert property (@(posedge clk) disable iff (rst)
        raise_trap |-> (cause != 3'd0));
    assert_quiet_no_cause_R3: assert property (@(posedge clk) disable iff (rst)
        !raise_trap |-> (cause == 3'd0));
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(cause) && $stable(flags) && $stable(raise_trap)));
    assert_invalid_first_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !exc_mask[0] && raw_flags[0]) |=> (raise_trap && cause == 3'd1 && flags == 6'h01));
    assert_nan_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any_nan && !(!exc_mask[0] && raw_flags[0])) |=> !raise_trap);
    assert_dbz_hides_den_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && raw_flags[2]) |=> !flags[1]);
    assert_daz_no_den_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && daz) |=> (!flags[1] && cause != 3'd2));
    assert_flush_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (res_sel == 2'd2) |-> (flags[4] && flags[5]));
endmodule

bind fpx_trap_arbiter fpx_trap_arbiter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .opa        (opa),
    .opb        (opb),
    .raw_flags  (raw_flags),
    .exc_mask   (exc_mask),
    .daz        (daz),
    .out_valid  (out_valid),
    .raise_trap (raise_trap),
    .cause      (cause),
    .flags      (flags),
    .res_sel    (res_sel)
);

// File: tb/fpx_trap_arbiter_test.sv
module fpx_trap_arbiter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] opa = 32'h3f800000;
    logic [31:0] opb = 32'h3f800000;
    logic [5:0]  raw_flags = '0;
    logic        res_tiny = 1'b0;
    logic        res_huge = 1'b0;
    logic        res_nan = 1'b0;
    logic [5:0]  exc_mask = 6'h3f;
    logic        ftz = 1'b0;
    logic        daz = 1'b0;
    logic        out_valid;
    logic        raise_trap;
    logic [2:0]  cause;
    logic [5:0]  flags;
    logic [1:0]  res_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] ONE  = 32'h3f800000;
    localparam logic [31:0] SNAN = 32'h7fa00000;
    localparam logic [31:0] QNAN = 32'h7fc00000;

    always #2 clk = ~clk;

    fpx_trap_arbiter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .raw_flags(raw_flags), .res_tiny(res_tiny), .res_huge(res_huge),
        .res_nan(res_nan), .exc_mask(exc_mask), .ftz(ftz), .daz(daz),
        .out_valid(out_valid), .raise_trap(raise_trap), .cause(cause),
        .flags(flags), .res_sel(res_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [5:0] raw,
                          input logic [5:0] msk, input logic tny, input logic hug,
                          input logic rnan, input logic fz, input logic dz);
        @(negedge clk);
        opa = a; opb = b; raw_flags = raw; exc_mask = msk;
        res_tiny = tny; res_huge = hug; res_nan = rnan; ftz = fz; daz = dz;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_v(input string req, input logic trp, input logic [2:0] cs,
                            input logic [5:0] fl, input logic [1:0] sel);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " trap"},  32'(raise_trap), 32'(trp));
        chk({req, " cause"}, 32'(cause), 32'(cs));
        chk({req, " flags"}, 32'(flags), 32'(fl));
        chk({req, " sel"},   32'(res_sel), 32'(sel));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 trap", 32'(raise_trap), 0);
        chk("R1 cause", 32'(cause), 0);
        chk("R1 flags", 32'(flags), 0);
        chk("R1 sel", 32'(res_sel), 0);
    endtask

    task automatic t_invalid_R4;
        run_op(ONE, ONE, 6'h07, 6'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        expect_v("R4", 1'b1, 3'd1, 6'h01, 2'd0);
    endtask

    task automatic t_two_nan_R5;
        run_op(SNAN, QNAN, 6'h01, 6'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_v("R5 two nan", 1'b0, 3'd0, 6'h01, 2'd1);
    endtask

    task automatic t_one_nan_R5;
        run_op(QNAN, ONE, 6'h02, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_v("R5 one nan", 1'b0, 3'd0, 6'h00, 2'd0);
    endtask

    task automatic t_denormal_R6;
        run_op(ONE, ONE, 6'h22, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_v("R6 den", 1'b1, 3'd2, 6'h02, 2'd0);
    endtask

    task automatic t_dbz_R6;
        run_op(ONE, 32'h0, 6'h06, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_v("R6 dbz", 1'b1, 3'd3, 6'h04, 2'd0);
        run_op(ONE, 32'h0, 6'h06, 6'h3f, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_v("R6 masked dbz", 1'b0, 3'd0, 6'h04, 2'd0);
    endtask

    task automatic t_daz_R7;
        run_op(ONE, ONE, 6'h02, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_v("R7", 1'b0, 3'd0, 6'h00, 2'd0);
    endtask

    task automatic t_res_nan_R8;
        run_op(ONE, ONE, 6'h01, 6'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_v("R8", 1'b0, 3'd0, 6'h01, 2'd0);
    endtask

    task automatic t_uf_of_R9;
        run_op(ONE, ONE, 6'h20, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_v("R9 uf first", 1'b1, 3'd5, 6'h30, 2'd0);
        run_op(ONE, ONE, 6'h28, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_v("R9 of", 1'b1, 3'd4, 6'h28, 2'd0);
    endtask

    task automatic t_inexact_R10;
        run_op(ONE, ONE, 6'h30, 6'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_v("R10 tiny", 1'b1, 3'd6, 6'h30, 2'd0);
        run_op(ONE, ONE, 6'h00, 6'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_v("R10 ftz", 1'b1, 3'd6, 6'h30, 2'd2);
        run_op(ONE, ONE, 6'h28, 6'h08, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_v("R10 huge", 1'b1, 3'd6, 6'h28, 2'd0);
    endtask

    task automatic t_no_trap_R11;
        run_op(ONE, ONE, 6'h28, 6'h3f, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_v("R11 copy", 1'b0, 3'd0, 6'h28, 2'd0);
        run_op(ONE, ONE, 6'h00, 6'h3f, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_v("R11 flush", 1'b0, 3'd0, 6'h30, 2'd2);
    endtask

    task automatic t_hold_R2;
        run_op(ONE, ONE, 6'h02, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_v("R2 strobe", 1'b1, 3'd2, 6'h02, 2'd0);
        raw_flags = 6'h01; exc_mask = 6'h00;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 hold valid", 32'(out_valid), 0);
            chk("R2 hold cause", 32'(cause), 32'd2);
            chk("R2 hold flags", 32'(flags), 32'h02);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 32'(out_valid), 0);
        rst = 1'b0;
        t_reset();
        t_invalid_R4();
        t_two_nan_R5();
        t_one_nan_R5();
        t_denormal_R6();
        t_dbz_R6();
        t_daz_R7();
        t_res_nan_R8();
        t_uf_of_R9();
        t_inexact_R10();
        t_no_trap_R11();
        t_hold_R2();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule